// File: doc/BRIEF.md
# Precision Time-of-Day Counter

This block keeps a running wall-clock time for packet timestamping. The time is a nanoseconds field that always stays below one billion, plus a seconds count held as a 32-bit low word and a parameterised high word (16 bits by default). On every clock the time moves forward by a programmable step. The step has a whole-nanosecond part and a 24-bit binary fraction of a nanosecond. The fraction is summed in its own accumulator, and each overflow of that accumulator adds one extra nanosecond.

Software controls the counter through a small synchronous register port with one write strobe, one read strobe and a three-bit address. Writes take effect at the next clock edge. The block supports loading the nanoseconds directly, setting the seconds with both words committed together, and stepping the time once by a signed nanosecond amount. The full current time is driven on two output buses for use by the timestamp capture logic next to the block.

Top module: `ptp_tod_core`

## Requirements
- R1: After reset, the time, both active step values and the staged fraction are all zero. While the whole-nanosecond step and the fraction step are both zero, the time does not change.
- R2: On each clock with no time write, the fraction accumulator gains the fraction step modulo 2^24, and the nanoseconds gain the whole step plus the accumulator's carry-out.
- R3: The fraction register (address 4) takes fraction bits [23:8] in its bits [15:0] and fraction bits [7:0] in its bits [31:24]; other bits are ignored. A write to it is staged and has no effect on the time. The staged value becomes active at the same edge where address 3 (whole step, bits [7:0]) is written. The step written at that edge is first used on the following edge.
- R4: When the nanoseconds reach or pass 1,000,000,000 after a step or an adjust, that amount is removed and the seconds gain one. A carry out of the low seconds word goes into the high word.
- R5: A write to address 2 only stages the high seconds word (bits [15:0]) and leaves the running time unchanged. A write to address 1 loads the whole seconds value from the staged high word and the written low word. On that edge the nanoseconds and the fraction accumulator hold their values.
- R6: A write to address 0 loads the nanoseconds from bits [29:0], and zero is a legal value. On that edge the seconds and the fraction accumulator hold their values.
- R7: A write to address 5 steps the time exactly once, by the magnitude in bits [29:0]. Bit 31 selects the direction: 1 subtracts, 0 adds. On that edge the periodic step is skipped. A subtraction that goes below zero borrows one second and leaves the nanoseconds at 1,000,000,000 plus the result.
- R8: A read strobe makes the read data register, on the next edge, take the value the addressed register had before that edge: 0 live nanoseconds, 1 live low seconds, 2 live high seconds, 3 active whole step, 4 active fraction in the layout of R3, and zero for 5, 6 and 7.
- R9: The nanoseconds output never reaches 1,000,000,000, and with no seconds write the seconds never move by more than one per clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset, released on the clock |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| tod_sec | output | 48 | Current seconds (high word above low word) |
| tod_ns | output | 30 | Current nanoseconds |

## Verification
The properties assume that software never writes a nanoseconds value or an adjust magnitude of one billion or more, because the block does not clamp such values. They also assume at most one register is written per cycle. The stimulus keeps to these limits by drawing nanosecond loads and adjust magnitudes modulo one billion and by leaving bit 30 of the adjust word clear. The random phase mixes all six write types and reads of all eight addresses with idle cycles, and a behavioural model checks every cycle, including edges where a wrap, a borrow and a low-word carry coincide with other writes.

// File: rtl/ptp_tod_pkg.sv
package ptp_tod_pkg;
  localparam int REG_W     = 32;
  localparam int NS_W      = 30;
  localparam int FRAC_W    = 24;
  localparam int SEC_LO_W  = 32;
  localparam int ADJ_SIGN  = 31;
  localparam logic [NS_W:0] NS_LIMIT_X = 31'd1_000_000_000;

  typedef enum logic [2:0] {
    RA_NS       = 3'd0,
    RA_SEC_LO   = 3'd1,
    RA_SEC_HI   = 3'd2,
    RA_INC_NS   = 3'd3,
    RA_INC_FRAC = 3'd4,
    RA_ADJUST   = 3'd5
  } reg_addr_e;

  // fraction <-> register layout: reg[15:0]=frac[23:8], reg[31:24]=frac[7:0]
  function automatic logic [FRAC_W-1:0] frac_from_reg(input logic [REG_W-1:0] w);
    return {w[15:0], w[31:24]};
  endfunction

  function automatic logic [REG_W-1:0] frac_to_reg(input logic [FRAC_W-1:0] f);
    return {f[7:0], 8'h00, f[23:8]};
  endfunction
endpackage

// File: rtl/ptp_tod_rst_sync.sv
module ptp_tod_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/ptp_tod_incr.sv
module ptp_tod_incr
  import ptp_tod_pkg::*;
#(
  parameter int INC_NS_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_frac,
  input  logic                wr_whole,
  input  logic [FRAC_W-1:0]   frac_in,
  input  logic [INC_NS_W-1:0] whole_in,
  output logic [INC_NS_W-1:0] inc_ns,
  output logic [FRAC_W-1:0]   inc_frac
);
  logic [FRAC_W-1:0]   stage_q, stage_d;
  logic [FRAC_W-1:0]   frac_q, frac_d;
  logic [INC_NS_W-1:0] whole_q, whole_d;

  always_comb begin
    stage_d = stage_q;
    frac_d  = frac_q;
    whole_d = whole_q;
    if (wr_frac) stage_d = frac_in;
    if (wr_whole) begin
      whole_d = whole_in;
      frac_d  = stage_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      frac_q  <= '0;
      whole_q <= '0;
    end else begin
      if (wr_frac)  stage_q <= stage_d;
      if (wr_whole) begin
        frac_q  <= frac_d;
        whole_q <= whole_d;
      end
    end
  end

  assign inc_ns   = whole_q;
  assign inc_frac = frac_q;
endmodule

// File: rtl/ptp_tod_step.sv
module ptp_tod_step
  import ptp_tod_pkg::*;
#(
  parameter int INC_NS_W = 8
) (
  input  logic [NS_W-1:0]     cur_ns,
  input  logic [FRAC_W-1:0]   cur_frac,
  input  logic [INC_NS_W-1:0] inc_ns,
  input  logic [FRAC_W-1:0]   inc_frac,
  input  logic                adj_neg,
  input  logic [NS_W-1:0]     adj_mag,
  output logic [NS_W-1:0]     tick_ns,
  output logic [FRAC_W-1:0]   tick_frac,
  output logic                tick_sec_up,
  output logic [NS_W-1:0]     adj_ns,
  output logic                adj_sec_up,
  output logic                adj_sec_dn
);
  localparam int XW = NS_W + 1;

  logic [FRAC_W:0] frac_sum;
  logic [XW-1:0]   tick_raw;
  logic [XW-1:0]   adj_sum;
  logic [XW-1:0]   adj_wrapped;

  always_comb begin
    frac_sum    = {1'b0, cur_frac} + {1'b0, inc_frac};
    tick_frac   = frac_sum[FRAC_W-1:0];
    tick_raw    = {1'b0, cur_ns} + XW'(inc_ns) + XW'(frac_sum[FRAC_W]);
    tick_sec_up = (tick_raw >= NS_LIMIT_X);
    tick_ns     = tick_sec_up ? NS_W'(tick_raw - NS_LIMIT_X) : tick_raw[NS_W-1:0];
  end

  always_comb begin
    adj_sum     = {1'b0, cur_ns} + {1'b0, adj_mag};
    adj_wrapped = {1'b0, cur_ns} + NS_LIMIT_X - {1'b0, adj_mag};
    adj_sec_up  = 1'b0;
    adj_sec_dn  = 1'b0;
    if (adj_neg) begin
      if (adj_mag > cur_ns) begin
        adj_ns     = NS_W'(adj_wrapped);
        adj_sec_dn = 1'b1;
      end else begin
        adj_ns = cur_ns - adj_mag;
      end
    end else if (adj_sum >= NS_LIMIT_X) begin
      adj_ns     = NS_W'(adj_sum - NS_LIMIT_X);
      adj_sec_up = 1'b1;
    end else begin
      adj_ns = adj_sum[NS_W-1:0];
    end
  end
endmodule

// File: rtl/ptp_tod_core.sv
module ptp_tod_core
  import ptp_tod_pkg::*;
#(
  parameter int SEC_HI_W = 16,
  parameter int INC_NS_W = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         reg_wr,
  input  logic                         reg_rd,
  input  logic [2:0]                   reg_addr,
  input  logic [REG_W-1:0]             reg_wdata,
  output logic [REG_W-1:0]             reg_rdata,
  output logic [SEC_LO_W+SEC_HI_W-1:0] tod_sec,
  output logic [NS_W-1:0]              tod_ns
);
  localparam int SEC_W = SEC_LO_W + SEC_HI_W;

  logic rst_sync_n;

  ptp_tod_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  logic wr_ns, wr_sec_lo, wr_sec_hi, wr_inc_ns, wr_inc_frac, wr_adj;
  assign wr_ns       = reg_wr && (reg_addr == RA_NS);
  assign wr_sec_lo   = reg_wr && (reg_addr == RA_SEC_LO);
  assign wr_sec_hi   = reg_wr && (reg_addr == RA_SEC_HI);
  assign wr_inc_ns   = reg_wr && (reg_addr == RA_INC_NS);
  assign wr_inc_frac = reg_wr && (reg_addr == RA_INC_FRAC);
  assign wr_adj      = reg_wr && (reg_addr == RA_ADJUST);

  logic [INC_NS_W-1:0] inc_ns;
  logic [FRAC_W-1:0]   inc_frac;

  ptp_tod_incr #(.INC_NS_W(INC_NS_W)) u_incr (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_frac  (wr_inc_frac),
    .wr_whole (wr_inc_ns),
    .frac_in  (frac_from_reg(reg_wdata)),
    .whole_in (reg_wdata[INC_NS_W-1:0]),
    .inc_ns   (inc_ns),
    .inc_frac (inc_frac)
  );

  logic [NS_W-1:0]     ns_q, ns_d;
  logic [SEC_W-1:0]    sec_q, sec_d;
  logic [FRAC_W-1:0]   acc_q, acc_d;
  logic [SEC_HI_W-1:0] hi_stage_q;
  logic [REG_W-1:0]    rdata_q, rdata_d;

  logic [NS_W-1:0]   tick_ns, adj_ns;
  logic [FRAC_W-1:0] tick_frac;
  logic              tick_sec_up, adj_sec_up, adj_sec_dn;

  ptp_tod_step #(.INC_NS_W(INC_NS_W)) u_step (
    .cur_ns      (ns_q),
    .cur_frac    (acc_q),
    .inc_ns      (inc_ns),
    .inc_frac    (inc_frac),
    .adj_neg     (reg_wdata[ADJ_SIGN]),
    .adj_mag     (reg_wdata[NS_W-1:0]),
    .tick_ns     (tick_ns),
    .tick_frac   (tick_frac),
    .tick_sec_up (tick_sec_up),
    .adj_ns      (adj_ns),
    .adj_sec_up  (adj_sec_up),
    .adj_sec_dn  (adj_sec_dn)
  );

  logic running, time_en;
  assign running = (|inc_ns) || (|inc_frac);
  assign time_en = wr_ns || wr_sec_lo || wr_adj || running;

  always_comb begin
    ns_d  = ns_q;
    sec_d = sec_q;
    acc_d = acc_q;
    if (wr_ns) begin
      ns_d = reg_wdata[NS_W-1:0];
    end else if (wr_sec_lo) begin
      sec_d = {hi_stage_q, reg_wdata[SEC_LO_W-1:0]};
    end else if (wr_adj) begin
      ns_d = adj_ns;
      if (adj_sec_up)      sec_d = sec_q + SEC_W'(1);
      else if (adj_sec_dn) sec_d = sec_q - SEC_W'(1);
    end else begin
      ns_d  = tick_ns;
      acc_d = tick_frac;
      if (tick_sec_up) sec_d = sec_q + SEC_W'(1);
    end
  end

  always_comb begin
    case (reg_addr)
      RA_NS:       rdata_d = REG_W'(ns_q);
      RA_SEC_LO:   rdata_d = sec_q[SEC_LO_W-1:0];
      RA_SEC_HI:   rdata_d = REG_W'(sec_q[SEC_W-1:SEC_LO_W]);
      RA_INC_NS:   rdata_d = REG_W'(inc_ns);
      RA_INC_FRAC: rdata_d = frac_to_reg(inc_frac);
      default:     rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ns_q       <= '0;
      sec_q      <= '0;
      acc_q      <= '0;
      hi_stage_q <= '0;
      rdata_q    <= '0;
    end else begin
      if (time_en) begin
        ns_q  <= ns_d;
        sec_q <= sec_d;
        acc_q <= acc_d;
      end
      if (wr_sec_hi) hi_stage_q <= reg_wdata[SEC_HI_W-1:0];
      if (reg_rd)    rdata_q    <= rdata_d;
    end
  end

  assign reg_rdata = rdata_q;
  assign tod_sec   = sec_q;
  assign tod_ns    = ns_q;
endmodule

// File: rtl/ptp_tod_checker.sv
module ptp_tod_checker
  import ptp_tod_pkg::*;
#(
  parameter int SEC_HI_W = 16
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         reg_wr,
  input logic [2:0]                   reg_addr,
  input logic [REG_W-1:0]             reg_wdata,
  input logic [SEC_LO_W+SEC_HI_W-1:0] tod_sec,
  input logic [NS_W-1:0]              tod_ns
);
  localparam int SEC_W = SEC_LO_W + SEC_HI_W;

  logic sec_write, adj_write, ns_write;
  assign sec_write = reg_wr && (reg_addr == RA_SEC_LO);
  assign adj_write = reg_wr && (reg_addr == RA_ADJUST);
  assign ns_write  = reg_wr && (reg_addr == RA_NS);

  assert_ns_below_limit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, tod_ns} < NS_LIMIT_X);

  assert_sec_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(sec_write || adj_write) |=>
      ((tod_sec == $past(tod_sec)) || (tod_sec == $past(tod_sec) + SEC_W'(1))));

  assert_ns_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ns_write |=> (tod_ns == $past(reg_wdata[NS_W-1:0])) && (tod_sec == $past(tod_sec)));

  assert_sec_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sec_write |=> (tod_sec[SEC_LO_W-1:0] == $past(reg_wdata)) && (tod_ns == $past(tod_ns)));

  assert_adjust_once_R7: assert property (@(posedge clk) disable iff (!rst_n)
    adj_write |=> ((tod_sec == $past(tod_sec)) ||
                   (tod_sec == $past(tod_sec) + SEC_W'(1)) ||
                   (tod_sec == $past(tod_sec) - SEC_W'(1))));
endmodule

bind ptp_tod_core ptp_tod_checker #(.SEC_HI_W(SEC_HI_W)) u_checker (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .tod_sec   (tod_sec),
  .tod_ns    (tod_ns)
);

// File: tb/ptp_tod_core_test.sv
module ptp_tod_core_test;
  localparam longint NS1 = 64'd1000000000;
  localparam longint SEC_MASK = (64'd1 << 48) - 1;

  logic        clk;
  logic        rst_n;
  logic        reg_wr;
  logic        reg_rd;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [47:0] tod_sec;
  logic [29:0] tod_ns;

  ptp_tod_core uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .tod_sec   (tod_sec),
    .tod_ns    (tod_ns)
  );

  initial clk = 1'b0;
  always #2ns clk = ~clk;

  int    n_chk = 0;
  int    n_fail = 0;
  int    cycles = 0;
  string cur_req = "R1";

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // behavioural reference model
  longint m_sec, m_ns, m_frac, m_inc_ns, m_inc_frac, m_stage, m_hi, m_rd;
  bit     rd_pending;

  task automatic model_tick();
    longint f;
    f = m_frac + m_inc_frac;
    m_frac = f % (64'd1 << 24);
    m_ns = m_ns + m_inc_ns + f / (64'd1 << 24);
    if (m_ns >= NS1) begin
      m_ns -= NS1;
      m_sec = (m_sec + 1) & SEC_MASK;
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sec = 0; m_ns = 0; m_frac = 0; m_inc_ns = 0; m_inc_frac = 0;
      m_stage = 0; m_hi = 0; m_rd = 0; rd_pending = 0;
    end else begin
      rd_pending = reg_rd;
      if (reg_rd) begin
        case (reg_addr)
          3'd0: m_rd = m_ns;
          3'd1: m_rd = m_sec & 64'hFFFF_FFFF;
          3'd2: m_rd = m_sec >> 32;
          3'd3: m_rd = m_inc_ns;
          3'd4: m_rd = ((m_inc_frac & 255) << 24) | (m_inc_frac >> 8);
          default: m_rd = 0;
        endcase
      end
      if (reg_wr && reg_addr == 3'd0) begin
        m_ns = longint'(reg_wdata[29:0]);
      end else if (reg_wr && reg_addr == 3'd1) begin
        m_sec = (m_hi << 32) | longint'(reg_wdata);
      end else if (reg_wr && reg_addr == 3'd5) begin
        if (reg_wdata[31]) begin
          m_ns -= longint'(reg_wdata[29:0]);
          if (m_ns < 0) begin
            m_ns += NS1;
            m_sec = (m_sec - 1) & SEC_MASK;
          end
        end else begin
          m_ns += longint'(reg_wdata[29:0]);
          if (m_ns >= NS1) begin
            m_ns -= NS1;
            m_sec = (m_sec + 1) & SEC_MASK;
          end
        end
      end else begin
        model_tick();
        if (reg_wr && reg_addr == 3'd2) m_hi = longint'(reg_wdata[15:0]);
        if (reg_wr && reg_addr == 3'd3) begin
          m_inc_ns   = longint'(reg_wdata[7:0]);
          m_inc_frac = m_stage;
        end
        if (reg_wr && reg_addr == 3'd4)
          m_stage = longint'({reg_wdata[15:0], reg_wdata[31:24]});
      end
    end
  end

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk(cur_req, longint'(tod_sec), m_sec);
      chk(cur_req, longint'(tod_ns), m_ns);
      if (rd_pending) chk("R8", longint'(reg_rdata), m_rd);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected below %0d", cycles, 100000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic do_write(input logic [2:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic do_read(input logic [2:0] a);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R1: reset state and stopped timer
    chk("R1", longint'(tod_sec), 0);
    chk("R1", longint'(tod_ns), 0);
    idle(5);
    chk("R1", longint'(tod_ns), 0);

    // R5: high word staged only, committed by the low word
    cur_req = "R5";
    do_write(3'd2, 32'hABCD_1234);
    chk("R5", longint'(tod_sec), 0);
    do_write(3'd1, 32'hFFFF_FFFF);
    chk("R5", longint'(tod_sec), 64'h1234_FFFF_FFFF);

    // R6: direct nanosecond load
    cur_req = "R6";
    do_write(3'd0, 32'd999_999_990);
    chk("R6", longint'(tod_ns), 999_999_990);

    // R3: staged fraction has no effect until whole step written
    cur_req = "R3";
    do_write(3'd4, 32'h0000_8000);   // fraction 0x800000 = one half
    idle(2);
    chk("R3", longint'(tod_ns), 999_999_990);
    do_write(3'd3, 32'd4);
    chk("R3", longint'(tod_ns), 999_999_990);
    @(negedge clk);
    chk("R2", longint'(tod_ns), 999_999_994);
    @(negedge clk);
    chk("R2", longint'(tod_ns), 999_999_999);

    // R4: wrap with carry out of the low seconds word
    cur_req = "R4";
    @(negedge clk);
    chk("R4", longint'(tod_ns), 3);
    chk("R4", longint'(tod_sec), 64'h1235_0000_0000);

    // R7: subtract with borrow, then add across the boundary, then zero
    cur_req = "R7";
    do_write(3'd5, 32'h8000_000A);
    chk("R7", longint'(tod_ns), 999_999_993);
    chk("R7", longint'(tod_sec), 64'h1234_FFFF_FFFF);
    do_write(3'd5, 32'd20);
    chk("R7", longint'(tod_ns), 13);
    chk("R7", longint'(tod_sec), 64'h1235_0000_0000);
    do_write(3'd5, 32'd0);
    chk("R7", longint'(tod_ns), 13);

    // R6: zero is legal; R2 next tick carries the half-ns accumulator
    cur_req = "R6";
    do_write(3'd0, 32'd0);
    chk("R6", longint'(tod_ns), 0);
    cur_req = "R2";
    @(negedge clk);
    chk("R2", longint'(tod_ns), 5);

    // R8: reads of configuration and unused addresses
    cur_req = "R8";
    do_read(3'd3);
    chk("R8", longint'(reg_rdata), 4);
    do_read(3'd4);
    chk("R8", longint'(reg_rdata), 64'h0000_8000);
    do_read(3'd2);
    chk("R8", longint'(reg_rdata), 64'h1235);
    do_read(3'd6);
    chk("R8", longint'(reg_rdata), 0);

    // R9: random mix of all operations
    cur_req = "R9";
    for (int i = 0; i < 4000; i++) begin
      int sel;
      sel = int'($urandom % 20);
      reg_rd = ($urandom % 3) == 0;
      reg_addr = 3'($urandom % 8);
      reg_wr = 1'b0;
      reg_wdata = $urandom;
      if (sel < 6) begin
        reg_wr = 1'b1;
        reg_addr = 3'(sel);
        if (sel == 0) reg_wdata = $urandom % 32'd1_000_000_000;
        if (sel == 5) reg_wdata = {1'($urandom), 1'b0, 30'($urandom % 32'd1_000_000_000)};
      end
      @(negedge clk);
    end
    reg_wr = 1'b0; reg_rd = 1'b0;

    // R1: both steps zero stops the timer
    cur_req = "R1";
    do_write(3'd4, 32'd0);
    do_write(3'd3, 32'd0);
    begin
      longint s0, n0;
      s0 = longint'(tod_sec); n0 = longint'(tod_ns);
      idle(6);
      chk("R1", longint'(tod_sec), s0);
      chk("R1", longint'(tod_ns), n0);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule